// File: doc/BRIEF.md
# Per-Slot Serial Clock and Chip-Select Timing Generator

This block derives the bit clock of a serial peripheral host from a fast reference clock, and frames each transfer with a chip-select window. Every device slot has a 32-bit parameter word. The word sets a rate multiplier `B` and three timing counts: setup, hold and inter-transfer gap. Each slot also has its own clock polarity and clock phase bit. The serial clock runs at `f_ref * B / 512`. The effective `B` is a power of two from 1 to 128, so the period ranges from 4 to 512 reference cycles.

A run request in the idle state starts a transfer. On that cycle the block latches the selected slot's settings and the bit count. The block then raises chip select, waits out the setup count, and emits two clock edges per bit. Each edge comes with a one-cycle shift or sample strobe, chosen by the slot's phase bit. After the last edge the block waits out the hold count, drops chip select, and stays unresponsive for the gap count. Data shifting and storage belong to a neighbouring block, which uses the strobes.

Top module: `serial_clk_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sclk_o`, `cs_o`, `shift_o` and `sample_o` are all 0.
- R2: In the idle state, `sclk_o` takes the polarity bit `cpol_i[dev_sel_i]` one cycle after `dev_sel_i` is presented.
- R3: While the clock runs, `sclk_o` toggles every `256/B` reference cycles. `B` comes from the multiplier field, bits 31:24 of the slot word, which sits at bits `[32*slot +: 32]` of `param_i`.
- R4: A multiplier field that is not a power of two behaves as its highest set bit. A field of 0 behaves as 1.
- R5: `cs_o` rises on the edge that accepts `run_i`. The first clock edge follows `setup+1` cycles later, plus one half period. Setup is bits 23:16 of the slot word.
- R6: A transfer of `len_i` bits gives exactly `2*len_i` clock edges and leaves `sclk_o` at the slot's polarity. When `len_i` is 0 there are no edges.
- R7: `cs_o` falls `hold+1` cycles after the last clock edge, or after setup ends when the length is 0. Hold is bits 15:8 of the slot word.
- R8: `run_i` is ignored from acceptance until `gap+1` cycles after `cs_o` falls, and the idle cycle that follows those cycles. Gap is bits 7:0. With `run_i` held high, `cs_o` stays low for exactly `gap+2` cycles between transfers.
- R9: Each clock edge comes with exactly one one-cycle strobe in the same cycle. With phase bit 0, the leading edges (1st, 3rd, ...) pulse `sample_o` and the trailing edges pulse `shift_o`. With phase bit 1 the two are swapped.
- R10: Slot settings, polarity, phase and length are taken when the run is accepted. Changes to `dev_sel_i` during a transfer have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Transfer request, sampled in idle |
| dev_sel_i | input | 3 | Selected device slot |
| len_i | input | 8 | Bits in the transfer |
| param_i | input | 256 | Eight 32-bit slot parameter words, slot n at [32n +: 32] |
| cpol_i | input | 8 | Clock polarity per slot |
| cpha_i | input | 8 | Clock phase per slot |
| sclk_o | output | 1 | Serial bit clock |
| shift_o | output | 1 | Strobe: launch next data bit on this edge |
| sample_o | output | 1 | Strobe: capture data on this edge |
| cs_o | output | 1 | Chip-select window, active high |

## Verification
The bench compares every cycle of each transfer against a timeline it computes itself. This catches an off-by-one in the setup, hold or gap counters: such an error moves the first edge or the chip-select fall by one cycle. It drives multiplier values of 0 and values that are not powers of two. A design that fed the raw field to the accumulator would produce irregular edge spacing, or no clock at all. The bench holds `run_i` high and scrambles `dev_sel_i` through a whole transfer. A design that re-armed early, or that read the live slot, would restart the window or change its rate mid-transfer. Both phase settings are used, so swapped strobe roles show up on the first edge.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;
  localparam int WORD_W  = 32;
  localparam int FIELD_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_HOLD,
    ST_GAP
  } seq_state_e;

  // field order fixes bit positions: rate 31:24, setup 23:16, hold 15:8, gap 7:0
  typedef struct packed {
    logic [FIELD_W-1:0] rate;
    logic [FIELD_W-1:0] setup;
    logic [FIELD_W-1:0] hold;
    logic [FIELD_W-1:0] gap;
  } slot_cfg_t;
endpackage

// File: rtl/sclk_rate_norm.sv
module sclk_rate_norm #(
  parameter int W = 8
) (
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] pow2_o
);
  // keep the highest set bit; zero maps to the slowest rate
  always_comb begin
    pow2_o = {{(W-1){1'b0}}, 1'b1};
    for (int i = 0; i < W; i++) begin
      if (raw_i[i]) pow2_o = W'(1) << i;
    end
  end
endmodule

// File: rtl/sclk_phase_acc.sv
module sclk_phase_acc #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] step_i,
  output logic         tick_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, step_i};
  assign tick_o = en_i & sum[W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (!en_i) acc_q <= '0;
    else            acc_q <= sum[W-1:0];
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sclk_seq_fsm.sv
module sclk_seq_fsm
  import sclk_gen_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  slot_cfg_t        cfg_i,
  input  logic             pol_i,
  input  logic             pha_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             tick_i,
  output logic             acc_en_o,
  output logic [FIELD_W-1:0] rate_o,
  output logic             sclk_o,
  output logic             shift_o,
  output logic             sample_o,
  output logic             cs_o
);
  localparam int EDGE_W = LEN_W + 1;

  seq_state_e         st_q;
  logic [FIELD_W-1:0] cnt_q, hold_q, gap_q, rate_q;
  logic [EDGE_W-1:0]  edges_q;
  logic               pol_q, pha_q, lead_q;
  logic               sclk_q, shift_q, sample_q, cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      cnt_q <= '0; hold_q <= '0; gap_q <= '0; rate_q <= '0;
      edges_q <= '0;
      pol_q <= 1'b0; pha_q <= 1'b0; lead_q <= 1'b1;
      sclk_q <= 1'b0; shift_q <= 1'b0; sample_q <= 1'b0; cs_q <= 1'b0;
    end else begin
      shift_q  <= 1'b0;
      sample_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          sclk_q <= pol_i;
          if (run_i) begin
            st_q    <= ST_SETUP;
            cnt_q   <= cfg_i.setup;
            hold_q  <= cfg_i.hold;
            gap_q   <= cfg_i.gap;
            rate_q  <= cfg_i.rate;
            pol_q   <= pol_i;
            pha_q   <= pha_i;
            lead_q  <= 1'b1;
            edges_q <= {len_i, 1'b0};
            cs_q    <= 1'b1;
          end
        end
        ST_SETUP: begin
          if (cnt_q == '0) begin
            st_q  <= (edges_q == '0) ? ST_HOLD : ST_ACTIVE;
            cnt_q <= hold_q;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_ACTIVE: begin
          if (tick_i) begin
            sclk_q   <= ~sclk_q;
            sample_q <= lead_q ^ pha_q;
            shift_q  <= ~(lead_q ^ pha_q);
            lead_q   <= ~lead_q;
            edges_q  <= edges_q - 1'b1;
            if (edges_q == EDGE_W'(1)) begin
              st_q  <= ST_HOLD;
              cnt_q <= hold_q;
            end
          end
        end
        ST_HOLD: begin
          if (cnt_q == '0) begin
            st_q  <= ST_GAP;
            cnt_q <= gap_q;
            cs_q  <= 1'b0;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_GAP: begin
          if (cnt_q == '0) st_q <= ST_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign acc_en_o = (st_q == ST_ACTIVE);
  assign rate_o   = rate_q;
  assign sclk_o   = sclk_q;
  assign shift_o  = shift_q;
  assign sample_o = sample_q;
  assign cs_o     = cs_q;

  // R6
  sclk_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD || st_q == ST_GAP) |-> (sclk_o == pol_q));
  // R9
  strobe_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_o || sample_o) |-> (sclk_o != $past(sclk_o)));
  // R7
  cs_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> ($past(st_q) == ST_HOLD));
  // R10
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |-> ($stable(rate_q) && $stable(pha_q)));
endmodule

// File: rtl/serial_clk_gen.sv
module serial_clk_gen
  import sclk_gen_pkg::*;
#(
  parameter int NDEV  = 8,
  parameter int LEN_W = 8,
  localparam int SEL_W = $clog2(NDEV)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   run_i,
  input  logic [SEL_W-1:0]       dev_sel_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [NDEV*WORD_W-1:0] param_i,
  input  logic [NDEV-1:0]        cpol_i,
  input  logic [NDEV-1:0]        cpha_i,
  output logic                   sclk_o,
  output logic                   shift_o,
  output logic                   sample_o,
  output logic                   cs_o
);
  slot_cfg_t          slot_cfg [NDEV];
  slot_cfg_t          sel_cfg, norm_cfg;
  logic [FIELD_W-1:0] rate_pow2, rate_run;
  logic               acc_en, tick;

  for (genvar g = 0; g < NDEV; g++) begin : g_slot
    assign slot_cfg[g] = slot_cfg_t'(param_i[g*WORD_W +: WORD_W]);
  end

  assign sel_cfg = slot_cfg[dev_sel_i];

  sclk_rate_norm #(.W(FIELD_W)) i_rate_norm (
    .raw_i  (sel_cfg.rate),
    .pow2_o (rate_pow2)
  );

  always_comb begin
    norm_cfg      = sel_cfg;
    norm_cfg.rate = rate_pow2;
  end

  sclk_seq_fsm #(.LEN_W(LEN_W)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .cfg_i    (norm_cfg),
    .pol_i    (cpol_i[dev_sel_i]),
    .pha_i    (cpha_i[dev_sel_i]),
    .len_i    (len_i),
    .tick_i   (tick),
    .acc_en_o (acc_en),
    .rate_o   (rate_run),
    .sclk_o   (sclk_o),
    .shift_o  (shift_o),
    .sample_o (sample_o),
    .cs_o     (cs_o)
  );

  sclk_phase_acc #(.W(FIELD_W)) i_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (acc_en),
    .step_i (rate_run),
    .tick_o (tick)
  );
endmodule

// File: tb/test_serial_clk_gen.sv
module test_serial_clk_gen;
  localparam int NDEV = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              run_i = 1'b0;
  logic [2:0]        dev_sel_i = '0;
  logic [7:0]        len_i = '0;
  logic [NDEV*32-1:0] param_i = '0;
  logic [NDEV-1:0]   cpol_i = '0;
  logic [NDEV-1:0]   cpha_i = '0;
  logic              sclk_o, shift_o, sample_o, cs_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10ns clk_i = ~clk_i;

  serial_clk_gen i_serial_clk_gen (
    .clk_i, .rst_ni, .run_i, .dev_sel_i, .len_i, .param_i,
    .cpol_i, .cpha_i, .sclk_o, .shift_o, .sample_o, .cs_o
  );

  function automatic int eff_rate(input int raw);
    int r = 1;
    for (int i = 0; i < 8; i++) if (raw[i]) r = 1 << i;
    return r;
  endfunction

  task automatic set_slot(input int d, input int rate, input int su, input int hd,
                          input int gp, input bit pol, input bit pha);
    param_i[d*32 +: 32] = {rate[7:0], su[7:0], hd[7:0], gp[7:0]};
    cpol_i[d] = pol;
    cpha_i[d] = pha;
  endtask

  task automatic chk(input string req, input int m, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s m=%0d {cs,sclk,shift,sample} actual=%b expected=%b", req, m, act, exp);
    end
  endtask

  // run_i must already be high with dev_sel_i/len_i set for this transfer
  task automatic xfer(input bit chain, input int nxt_dev, input int nxt_len);
    int d = dev_sel_i;
    int len = len_i;
    int su = param_i[d*32+16 +: 8];
    int hd = param_i[d*32+8 +: 8];
    int gp = param_i[d*32 +: 8];
    int h = 256 / eff_rate(param_i[d*32+24 +: 8]);
    bit pol = cpol_i[d];
    bit pha = cpha_i[d];
    int ml = su + 1 + 2*len*h;
    int mi = ml + hd + 1 + gp + 1;
    int n_edge = 0, n_samp = 0;
    logic prev = pol;
    @(posedge clk_i);
    for (int m = 0; m <= mi; m++) begin
      int k, e;
      logic [3:0] ex;
      string tag;
      @(negedge clk_i);
      k = m - (su + 1);
      e = (k <= 0) ? 0 : k / h;
      if (e > 2*len) e = 2*len;
      ex = 4'b0;
      ex[3] = (m < ml + hd + 1);
      ex[2] = pol ^ e[0];
      if (k > 0 && (k % h) == 0 && (k / h) <= 2*len) begin
        logic s = ((k / h) % 2 == 1) ^ pha;
        ex[0] = s;
        ex[1] = ~s;
      end
      if (m <= su) tag = "R5";
      else if (m <= ml) tag = "R3";
      else if (m <= ml + hd + 1) tag = "R7";
      else tag = "R8";
      chk(tag, m, {cs_o, sclk_o, shift_o, sample_o}, ex);
      if (sclk_o !== prev) n_edge++;
      if (sample_o) n_samp++;
      prev = sclk_o;
      if (m < mi) dev_sel_i = 3'($urandom % NDEV); // R10: ignored mid-transfer
      else begin
        dev_sel_i = 3'(nxt_dev);
        len_i = 8'(nxt_len);
        if (!chain) run_i = 1'b0;
      end
    end
    // R6: edge count and resting level
    chk("R6", -1, {2'b0, 1'b0, n_edge == 2*len}, 4'b0001);
    // R9: one sample strobe per bit
    chk("R9", -1, {3'b0, n_samp == len}, 4'b0001);
    if (!chain) begin
      @(negedge clk_i);
      // R8: no restart; R2: idle level follows the newly selected slot
      chk("R8", mi + 1, {cs_o, sclk_o, shift_o, sample_o}, {1'b0, cpol_i[nxt_dev], 2'b00});
    end
  endtask

  task automatic start(input int d, input int len);
    @(negedge clk_i);
    dev_sel_i = 3'(d);
    len_i = 8'(len);
    run_i = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5c1c_0a7e));
    set_slot(0, 128, 0, 0, 0, 1'b0, 1'b0);
    set_slot(1, 128, 3, 2, 4, 1'b1, 1'b1);
    set_slot(2, 1, 1, 1, 1, 1'b0, 1'b1);
    set_slot(3, 0, 0, 0, 0, 1'b1, 1'b0);
    set_slot(4, 8'h5a, 2, 5, 0, 1'b0, 1'b0);
    set_slot(5, 32, 255, 255, 255, 1'b1, 1'b0);
    set_slot(6, 16, 7, 0, 3, 1'b0, 1'b1);
    set_slot(7, 8'hff, 0, 9, 2, 1'b1, 1'b1);
    repeat (3) @(negedge clk_i);
    // R1: reset values
    chk("R1", 0, {cs_o, sclk_o, shift_o, sample_o}, 4'b0000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", 0, {cs_o, shift_o, sample_o}, 3'b000);
    // R2: idle level per slot
    for (int d = 0; d < NDEV; d++) begin
      dev_sel_i = 3'(d);
      @(negedge clk_i);
      chk("R2", d, {3'b0, sclk_o}, {3'b0, cpol_i[d]});
    end
    start(0, 3); xfer(0, 1, 0);    // fastest rate, zero timings
    start(1, 2); xfer(0, 3, 0);    // polarity 1, phase 1
    start(2, 1); xfer(0, 0, 0);    // slowest rate
    start(3, 1); xfer(0, 4, 0);    // R4: field 0 -> 1
    start(4, 2); xfer(0, 7, 0);    // R4: 0x5a -> 64
    start(7, 2); xfer(0, 1, 0);    // R4: 0xff -> 128
    start(1, 0); xfer(0, 5, 0);    // R6: zero length
    start(5, 1); xfer(0, 6, 1);    // maximum setup/hold/gap
    start(6, 2); xfer(1, 1, 1);    // R8: back-to-back with run held
    xfer(1, 0, 2);
    xfer(0, 0, 0);
    for (int t = 0; t < 24; t++) begin
      int d = $urandom % NDEV;
      set_slot(d, $urandom % 256, $urandom % 12, $urandom % 12, $urandom % 12,
               1'($urandom), 1'($urandom));
      start(d, $urandom % 5);
      xfer(0, $urandom % NDEV, 0);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule